// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block forms the top level of the interrupt tree of a USB device controller. Five groups of sub-status registers sit outside it: the serial engine, the general endpoints, DMA, FIFO and endpoint 0. Each group hands in its raw cause vector together with its own enable vector. The block reduces each pair to a single summary bit, which is 1 while any enabled cause in the group is pending. It also keeps one cause of its own, a sticky flag that is set when the eight bytes of a SETUP packet have been stored at the end of a setup stage. Software clears that flag by writing 1 to its bit.

All six causes share one status byte, and a main enable byte sits beside it. The active-low interrupt line to the CPU is asserted while any status bit is set and its main enable bit is also set. The summary bits need no write to clear them: they drop as soon as the enabled causes beneath them are cleared at their source. The same SETUP capture that raises the flag also loads the endpoint-0 IN and OUT control fields with a fixed handshake state: stall off, NAK on, toggle status on. Software reaches those two control fields, the status byte and the enable byte through a byte-wide register port. Reads on that port are combinational and have no side effects.

Top module: `usb_irq_aggregator`

## Requirements
- R1: The status byte (address 0) places the serial-engine summary at bit 7, the general-endpoint summary at bit 6, the DMA summary at bit 5, the FIFO summary at bit 4, the endpoint-0 summary at bit 1 and the SETUP-received flag at bit 0.
- R2: Each summary bit is 1 exactly when its group's raw vector AND its enable vector is non-zero, and it returns to 0 once those enabled causes are gone.
- R3: A write to address 0 leaves the summary bits unaffected.
- R4: Bits 3 and 2 read as 0 at address 0 and at the main enable register (address 1), whatever is written there; the other enable bits read back as written.
- R5: The SETUP-received flag is 1 in the cycle after a `setup_done` pulse. A write to address 0 with bit 0 set clears it on the next edge, and a write with bit 0 clear leaves it unchanged.
- R6: When `setup_done` and a clearing write to address 0 fall in the same cycle, the flag ends up 1.
- R7: In the cycle after `setup_done`, both endpoint-0 control fields hold stall=0, NAK=1, toggle=1, i.e. 3'b011 with the layout {stall, NAK, toggle} in bits [2:0].
- R8: The IN control field is written and read at address 2 and the OUT control field at address 3, in bits [2:0] with bits [7:3] reading 0. A `setup_done` in the same cycle overrides such a write.
- R9: `irq_n` is 0 exactly when (status AND main enable) is non-zero, and the interrupt path contains no register.
- R10: After reset the main enable register, the SETUP flag and both control fields are 0 and `irq_n` is 1.
- R11: The summary bits, the serial-engine summary in particular, follow their inputs with no clock running, so they stay readable while the controller's clock is stopped in snooze.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sie_raw | input | SIE_W | Serial-engine raw causes |
| sie_en | input | SIE_W | Serial-engine cause enables |
| epr_raw | input | EPR_W | General-endpoint raw causes |
| epr_en | input | EPR_W | General-endpoint cause enables |
| dma_raw | input | DMA_W | DMA raw causes |
| dma_en | input | DMA_W | DMA cause enables |
| fifo_raw | input | FIFO_W | FIFO raw causes |
| fifo_en | input | FIFO_W | FIFO cause enables |
| ep0_raw | input | EP0_W | Endpoint-0 raw causes |
| ep0_en | input | EP0_W | Endpoint-0 cause enables |
| setup_done | input | 1 | One-cycle pulse: SETUP bytes stored |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 EP0 IN control, 3 EP0 OUT control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ep0_in_ctl | output | 3 | Endpoint-0 IN control {stall, NAK, toggle} |
| ep0_out_ctl | output | 3 | Endpoint-0 OUT control {stall, NAK, toggle} |
| irq_n | output | 1 | Active-low CPU interrupt |

## Verification
The assertions assume that every input is synchronous to `clk` and settles before the rising edge. They also assume that `setup_done` means a capture in exactly the cycle it is high, and that the register strobe, address and data are sampled together. The stimulus drives all inputs only on the falling edge and holds them through the following rising edge. The one exception is the stopped-clock check, where the raw and enable vectors are changed with the clock halted, and only combinational read paths are sampled then. The random phase sends SETUP pulses, writes and clears to any address, so capture and clear often coincide.

// File: rtl/usb_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the USB interrupt aggregator: status bit positions,
// register addresses and the endpoint-0 control field layout.
package usb_irq_pkg;
    localparam int ST_SIE   = 7;
    localparam int ST_EPR   = 6;
    localparam int ST_DMA   = 5;
    localparam int ST_FIFO  = 4;
    localparam int ST_EP0   = 1;
    localparam int ST_SETUP = 0;
    localparam int BYTE_W   = 8;
    localparam logic [BYTE_W-1:0] RSVD_MASK = 8'h0C;

    localparam int CTL_W     = 3;
    localparam int CTL_STALL = 2;
    localparam int CTL_NAK   = 1;
    localparam int CTL_TOG   = 0;
    localparam logic [CTL_W-1:0] CTL_ON_SETUP = 3'b011;

    typedef enum logic [1:0] {
        A_STATUS  = 2'd0,
        A_ENABLE  = 2'd1,
        A_EP0_IN  = 2'd2,
        A_EP0_OUT = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_group_or.sv
`timescale 1ns/1ps
// Reduces one group's raw cause vector under its enable vector to a single
// summary bit. Purely combinational so it stays valid with the clock stopped.
// Assumes raw and enable vectors are of equal width W.
module irq_group_or #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] en,
    output logic         hit
);
    // Any enabled cause pending raises the summary.
    assign hit = |(raw & en);
endmodule

// File: rtl/setup_flag.sv
`timescale 1ns/1ps
// Sticky SETUP-received flag: set by a capture pulse, cleared by a
// write-1 request; a capture in the same cycle as a clear wins.
module setup_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic clear,
    output logic flag_q
);
    // Flag update with capture priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (capture) flag_q <= 1'b1;
        else if (clear)   flag_q <= 1'b0;
    end
endmodule

// File: rtl/ep0_ctl_reg.sv
`timescale 1ns/1ps
// One endpoint-0 direction control field {stall, NAK, toggle}. Software may
// write it; a SETUP capture forces the fixed post-setup handshake state and
// overrides a write in the same cycle.
module ep0_ctl_reg
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_cap,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q
);
    // Control field update: capture beats software write.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= '0;
        else if (setup_cap) ctl_q <= CTL_ON_SETUP;
        else if (wr_en)     ctl_q <= wdata;
    end
endmodule

// File: rtl/usb_irq_aggregator.sv
`timescale 1ns/1ps
// Top-level interrupt status/enable for a USB device controller. Builds the
// main status byte from five group summaries plus a sticky SETUP flag, masks
// it with the main enable byte to drive an active-low interrupt, and holds the
// endpoint-0 control fields that a SETUP capture forces. Assumes all inputs
// are synchronous to clk; register reads are combinational and side-effect free.
module usb_irq_aggregator
    import usb_irq_pkg::*;
#(
    parameter int SIE_W  = 8,
    parameter int EPR_W  = 16,
    parameter int DMA_W  = 4,
    parameter int FIFO_W = 4,
    parameter int EP0_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SIE_W-1:0]   sie_raw,
    input  logic [SIE_W-1:0]   sie_en,
    input  logic [EPR_W-1:0]   epr_raw,
    input  logic [EPR_W-1:0]   epr_en,
    input  logic [DMA_W-1:0]   dma_raw,
    input  logic [DMA_W-1:0]   dma_en,
    input  logic [FIFO_W-1:0]  fifo_raw,
    input  logic [FIFO_W-1:0]  fifo_en,
    input  logic [EP0_W-1:0]   ep0_raw,
    input  logic [EP0_W-1:0]   ep0_en,
    input  logic               setup_done,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    output logic [CTL_W-1:0]   ep0_in_ctl,
    output logic [CTL_W-1:0]   ep0_out_ctl,
    output logic               irq_n
);
    localparam int N_DIR = 2;

    logic              sum_sie, sum_epr, sum_dma, sum_fifo, sum_ep0;
    logic              setup_q;
    logic              clr_setup;
    logic [BYTE_W-1:0] en_q;
    logic [BYTE_W-1:0] stat_vec;
    logic [CTL_W-1:0]  ctl_q [N_DIR];

    irq_group_or #(.W(SIE_W))  u_sum_sie  (.raw(sie_raw),  .en(sie_en),  .hit(sum_sie));
    irq_group_or #(.W(EPR_W))  u_sum_epr  (.raw(epr_raw),  .en(epr_en),  .hit(sum_epr));
    irq_group_or #(.W(DMA_W))  u_sum_dma  (.raw(dma_raw),  .en(dma_en),  .hit(sum_dma));
    irq_group_or #(.W(FIFO_W)) u_sum_fifo (.raw(fifo_raw), .en(fifo_en), .hit(sum_fifo));
    irq_group_or #(.W(EP0_W))  u_sum_ep0  (.raw(ep0_raw),  .en(ep0_en),  .hit(sum_ep0));

    // Write-1-to-clear decode for the SETUP flag.
    assign clr_setup = reg_wr && (reg_addr == A_STATUS) && reg_wdata[ST_SETUP];

    setup_flag u_setup (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (setup_done),
        .clear   (clr_setup),
        .flag_q  (setup_q)
    );

    // One control field per direction; index 0 is IN, index 1 is OUT.
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        localparam logic [1:0] DIR_ADDR = (d == 0) ? A_EP0_IN : A_EP0_OUT;
        ep0_ctl_reg u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .setup_cap (setup_done),
            .wr_en     (reg_wr && (reg_addr == DIR_ADDR)),
            .wdata     (reg_wdata[CTL_W-1:0]),
            .ctl_q     (ctl_q[d])
        );
    end
    assign ep0_in_ctl  = ctl_q[0];
    assign ep0_out_ctl = ctl_q[1];

    // Main enable register; reserved positions are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                              en_q <= '0;
        else if (reg_wr && reg_addr == A_ENABLE) en_q <= reg_wdata & ~RSVD_MASK;
    end

    // Assemble the status byte from summaries and the direct flag.
    always_comb begin
        stat_vec           = '0;
        stat_vec[ST_SIE]   = sum_sie;
        stat_vec[ST_EPR]   = sum_epr;
        stat_vec[ST_DMA]   = sum_dma;
        stat_vec[ST_FIFO]  = sum_fifo;
        stat_vec[ST_EP0]   = sum_ep0;
        stat_vec[ST_SETUP] = setup_q;
    end

    // Unregistered interrupt output.
    assign irq_n = ~|(stat_vec & en_q);

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS:  reg_rdata = stat_vec;
            A_ENABLE:  reg_rdata = en_q;
            A_EP0_IN:  reg_rdata[CTL_W-1:0] = ctl_q[0];
            default:   reg_rdata[CTL_W-1:0] = ctl_q[1];
        endcase
    end
endmodule

// File: rtl/usb_irq_aggregator_chk.sv
`timescale 1ns/1ps
// Assertion checker for usb_irq_aggregator, attached by bind. It observes the
// ports plus the internal SETUP flag and main enable register.
module usb_irq_aggregator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       setup_done,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [2:0] ep0_in_ctl,
    input logic [2:0] ep0_out_ctl,
    input logic       irq_n,
    input logic       flag,
    input logic [7:0] en_q
);
    logic clr_req;
    assign clr_req = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];

    AST_SETUP_SETS: assert property (@(posedge clk) disable iff (!rst_n) setup_done |=> flag); // R5
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n) (!setup_done && clr_req) |=> !flag); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!setup_done && !clr_req) |=> $stable(flag)); // R5
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (setup_done && clr_req) |=> flag); // R6
    AST_IN_FORCED: assert property (@(posedge clk) disable iff (!rst_n) setup_done |=> (ep0_in_ctl == 3'b011)); // R7
    AST_OUT_FORCED: assert property (@(posedge clk) disable iff (!rst_n) setup_done |=> (ep0_out_ctl == 3'b011)); // R7
    AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!setup_done && !(reg_wr && reg_addr[1])) |=> ($stable(ep0_in_ctl) && $stable(ep0_out_ctl))); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!reg_addr[1]) |-> (reg_rdata[3:2] == 2'b00)); // R4
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (en_q == 8'h00) |-> irq_n); // R9
    AST_IRQ_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (flag && en_q[0]) |-> !irq_n); // R9
endmodule

bind usb_irq_aggregator usb_irq_aggregator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_done  (setup_done),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ep0_in_ctl  (ep0_in_ctl),
    .ep0_out_ctl (ep0_out_ctl),
    .irq_n       (irq_n),
    .flag        (setup_q),
    .en_q        (en_q)
);

// File: tb/sim_usb_irq_aggregator.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated after every rising edge and
// compared against read data and irq_n before each following edge.
module sim_usb_irq_aggregator;
    localparam int CLK_P  = 10;
    localparam int SIE_W  = 8;
    localparam int EPR_W  = 16;
    localparam int DMA_W  = 4;
    localparam int FIFO_W = 4;
    localparam int EP0_W  = 6;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    bit   clk_run = 1'b1;
    logic rst_n;
    logic [SIE_W-1:0]  sie_raw, sie_en;
    logic [EPR_W-1:0]  epr_raw, epr_en;
    logic [DMA_W-1:0]  dma_raw, dma_en;
    logic [FIFO_W-1:0] fifo_raw, fifo_en;
    logic [EP0_W-1:0]  ep0_raw, ep0_en;
    logic       setup_done, reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [2:0] ep0_in_ctl, ep0_out_ctl;
    logic       irq_n;

    // Reference state
    int unsigned m_en, m_flag, m_in, m_out;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) if (clk_run) clk = ~clk;

    usb_irq_aggregator #(
        .SIE_W(SIE_W), .EPR_W(EPR_W), .DMA_W(DMA_W), .FIFO_W(FIFO_W), .EP0_W(EP0_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .sie_raw(sie_raw), .sie_en(sie_en), .epr_raw(epr_raw), .epr_en(epr_en),
        .dma_raw(dma_raw), .dma_en(dma_en), .fifo_raw(fifo_raw), .fifo_en(fifo_en),
        .ep0_raw(ep0_raw), .ep0_en(ep0_en),
        .setup_done(setup_done), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ep0_in_ctl(ep0_in_ctl), .ep0_out_ctl(ep0_out_ctl), .irq_n(irq_n)
    );

    function automatic logic [7:0] exp_status();
        logic [7:0] s = 8'h00;
        s[7] = (sie_raw & sie_en) != 0;
        s[6] = (epr_raw & epr_en) != 0;
        s[5] = (dma_raw & dma_en) != 0;
        s[4] = (fifo_raw & fifo_en) != 0;
        s[1] = (ep0_raw & ep0_en) != 0;
        s[0] = m_flag[0];
        return s;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return exp_status();
            2'd1:    return m_en[7:0];
            2'd2:    return {5'b0, m_in[2:0]};
            default: return {5'b0, m_out[2:0]};
        endcase
    endfunction

    function automatic logic exp_irq();
        return (exp_status() & m_en[7:0]) == 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_now(input string req);
        check(req, reg_rdata, exp_read(reg_addr));
        check({req, "/R9"}, {7'b0, irq_n}, {7'b0, exp_irq()});
        check({req, "/R7R8"}, {2'b0, ep0_in_ctl, ep0_out_ctl}, {2'b0, m_in[2:0], m_out[2:0]});
    endtask

    // One clock: drive at falling edge, compare before rise, update model after rise.
    task automatic step(input string req, input logic sd, input logic wr,
                        input logic [1:0] a, input logic [7:0] wd);
        @(negedge clk);
        setup_done = sd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        compare_now(req);
        @(posedge clk);
        #1;
        if (wr && a == 2'd1) m_en = wd & 8'hF3;
        if (sd) begin
            m_flag = 1; m_in = 3; m_out = 3;
        end else if (wr) begin
            if (a == 2'd0 && wd[0]) m_flag = 0;
            if (a == 2'd2) m_in = wd[2:0];
            if (a == 2'd3) m_out = wd[2:0];
        end
    endtask

    task automatic rd(input string req, input logic [1:0] a);
        step(req, 1'b0, 1'b0, a, 8'h00);
    endtask

    task automatic set_raw_zero();
        sie_raw = '0; epr_raw = '0; dma_raw = '0; fifo_raw = '0; ep0_raw = '0;
        sie_en = '1; epr_en = '1; dma_en = '1; fifo_en = '1; ep0_en = '1;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; setup_done = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        set_raw_zero();
        m_en = 0; m_flag = 0; m_in = 0; m_out = 0;
        repeat (3) @(posedge clk);
        // R10: reset values visible at every address
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); reg_addr = a[1:0]; #1;
            compare_now("R10");
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: each group lands on its own bit position
        m_en = 0;
        sie_raw = 8'h10; rd("R1 sie bit7", 2'd0);
        sie_raw = 0; epr_raw = 16'h8000; rd("R1 epr bit6", 2'd0);
        epr_raw = 0; dma_raw = 4'h2; rd("R1 dma bit5", 2'd0);
        dma_raw = 0; fifo_raw = 4'h1; rd("R1 fifo bit4", 2'd0);
        fifo_raw = 0; ep0_raw = 6'h20; rd("R1 ep0 bit1", 2'd0);

        // R2: masking by group enable and self-clearing
        ep0_en = 6'h1F; rd("R2 masked", 2'd0);
        ep0_en = 6'h20; rd("R2 enabled", 2'd0);
        ep0_raw = 0; rd("R2 self-clear", 2'd0);
        sie_raw = 8'hA5; sie_en = 8'h5A; rd("R2 disjoint", 2'd0);

        // R3: writes to status leave summaries alone
        sie_en = 8'h01; dma_raw = 4'h8;
        step("R3 write zeros", 1'b0, 1'b1, 2'd0, 8'h00);
        rd("R3 summaries kept", 2'd0);
        step("R3 write ones", 1'b0, 1'b1, 2'd0, 8'hFE);
        rd("R3 summaries kept", 2'd0);

        // R4: reserved bits read zero
        step("R4 enable write", 1'b0, 1'b1, 2'd1, 8'hFF);
        rd("R4 enable readback", 2'd1);
        rd("R4 status reserved", 2'd0);
        step("R4 enable clear", 1'b0, 1'b1, 2'd1, 8'h00);

        // R5: set, write-0 no effect, write-1 clear
        step("R5 capture", 1'b1, 1'b0, 2'd0, 8'h00);
        rd("R5 flag set", 2'd0);
        step("R5 write 0", 1'b0, 1'b1, 2'd0, 8'h00);
        rd("R5 flag held", 2'd0);
        step("R5 write 1", 1'b0, 1'b1, 2'd0, 8'h01);
        rd("R5 flag cleared", 2'd0);

        // R6: capture beats clear
        step("R6 collide", 1'b1, 1'b1, 2'd0, 8'h01);
        rd("R6 flag kept", 2'd0);
        step("R6 tidy", 1'b0, 1'b1, 2'd0, 8'h01);

        // R7: capture forces both control fields
        step("R7 preset in", 1'b0, 1'b1, 2'd2, 8'h04);
        step("R7 preset out", 1'b0, 1'b1, 2'd3, 8'h04);
        rd("R7 preset", 2'd3);
        step("R7 capture", 1'b1, 1'b0, 2'd0, 8'h00);
        rd("R7 in forced", 2'd2);
        rd("R7 out forced", 2'd3);

        // R8: software write and capture override
        step("R8 write in", 1'b0, 1'b1, 2'd2, 8'hFD);
        rd("R8 in readback", 2'd2);
        step("R8 write out", 1'b0, 1'b1, 2'd3, 8'h06);
        rd("R8 out readback", 2'd3);
        step("R8 override", 1'b1, 1'b1, 2'd3, 8'h04);
        rd("R8 out overridden", 2'd3);

        // R9: interrupt line gating
        step("R9 enable flag", 1'b0, 1'b1, 2'd1, 8'h01);
        rd("R9 irq low", 2'd0);
        step("R9 clear flag", 1'b0, 1'b1, 2'd0, 8'h01);
        rd("R9 irq high", 2'd0);
        step("R9 enable dma", 1'b0, 1'b1, 2'd1, 8'h20);
        rd("R9 dma irq", 2'd0);
        dma_raw = 0; rd("R9 dma gone", 2'd0);

        // R11: summaries respond with the clock stopped
        @(negedge clk); reg_wr = 0; setup_done = 0; reg_addr = 2'd0;
        clk_run = 1'b0;
        #(CLK_P);
        sie_raw = 8'h40; sie_en = 8'h40; #(CLK_P);
        compare_now("R11 stopped set");
        sie_en = 8'h00; #(CLK_P);
        compare_now("R11 stopped clear");
        clk_run = 1'b1;

        // Random phase covering all rules together (R2 R5 R6 R7 R8 R9)
        for (int i = 0; i < 3000; i++) begin
            logic sd, wr;
            logic [1:0] a;
            logic [7:0] wd;
            sie_raw  = $urandom & $urandom; sie_en  = $urandom;
            epr_raw  = $urandom & $urandom; epr_en  = $urandom;
            dma_raw  = $urandom & $urandom; dma_en  = $urandom;
            fifo_raw = $urandom & $urandom; fifo_en = $urandom;
            ep0_raw  = $urandom & $urandom; ep0_en  = $urandom;
            sd = ($urandom % 8) == 0;
            wr = ($urandom % 3) == 0;
            a  = $urandom;
            wd = $urandom;
            step("random", sd, wr, a, wd);
        end
        finish_up();
    end
endmodule